// File: doc/BRIEF.md
# Ping-Pong Buffer Descriptor Manager

This block keeps the descriptor state for a single peripheral DMA channel that moves data either from memory to a peripheral or from a peripheral to memory. It holds two buffer descriptors. Each descriptor has a base address, a byte count and a valid flag. At any time one descriptor is active. The block produces the memory address of the next peripheral data unit, and it counts down the bytes that remain in the active buffer.

Software loads one descriptor while the channel works through the other. When the active buffer finishes, the channel moves to the other descriptor on the same clock edge, so a slow refill does not cause an underrun or an overrun. A buffer finishes when its count is used up, or early when the peripheral ends it. The buffer length does not depend on the peripheral packet size. On each finish the block records whether the whole programmed count was moved and raises a maskable interrupt. If the other descriptor has not been loaded, the channel stalls and reports that it is starved.

Top module: `pingpong_desc_mgr`

## Requirements
- R1: After reset the channel is idle: `busy`, `done`, `irq`, `starved` and `cnt_match` are all 0, and `active_idx` is 0.
- R2: A write with `cfg_wr`=1 stores `cfg_base` and `cfg_count` into slot `cfg_sel` and marks that slot valid on the next edge. When the channel is idle and the slot at `active_idx` is valid, the next edge loads it: `busy`=1, `cur_addr` takes the base and `rem_cnt` takes the count.
- R3: Each `unit_done` pulse on a busy channel that does not finish the buffer adds the access step to `cur_addr` and subtracts it from `rem_cnt`. The step is 1 when `size_word`=0 (byte) and 4 when `size_word`=1 (word).
- R4: A unit that arrives while `rem_cnt` is at most the step finishes the buffer. This covers a last word that is only partly used. On the next edge `done` is high for exactly one cycle, `done_idx` gives the slot that finished, and `cnt_match`=1.
- R5: When a buffer finishes and the other slot is valid, `active_idx` toggles on that same edge. `busy` stays 1, and `cur_addr`/`rem_cnt` take the other slot's base and count.
- R6: A finished slot loses its valid flag. When a buffer finishes and the other slot is not valid, `active_idx` still toggles, `busy` drops to 0 and `starved` goes to 1. A later write to that slot loads it (R2) and clears `starved`.
- R7: While the channel is busy, a descriptor write aimed at the active slot is ignored, and `cur_addr` and `rem_cnt` keep their values.
- R8: `early_end` on a busy channel finishes the active buffer at once, with the same rollover as a normal finish, and sets `cnt_match`=0.
- R9: Each finish latches a pending interrupt. `irq` equals the pending bit gated by `irq_en`, and `irq_ack` clears the pending bit. A finish that occurs while `irq_en`=0 stays pending and appears on `irq` once `irq_en` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Descriptor write strobe |
| cfg_sel | input | 1 | Slot addressed by the write |
| cfg_base | input | AW | Base address to store |
| cfg_count | input | CW | Byte count to store |
| size_word | input | 1 | Access width: 0 byte, 1 word |
| unit_done | input | 1 | One peripheral data unit moved |
| early_end | input | 1 | Peripheral ends the active buffer now |
| irq_en | input | 1 | Interrupt enable (mask when 0) |
| irq_ack | input | 1 | Clears the pending interrupt |
| cur_addr | output | AW | Memory address of the next unit |
| rem_cnt | output | CW | Bytes left in the active buffer |
| busy | output | 1 | A descriptor is active |
| active_idx | output | 1 | Index of the active or next slot |
| done | output | 1 | One-cycle buffer-finished pulse |
| done_idx | output | 1 | Slot that last finished |
| cnt_match | output | 1 | Last finished buffer moved its full count |
| starved | output | 1 | Stalled because the next slot was empty |
| irq | output | 1 | Channel interrupt |

## Verification
The bench covers a word buffer whose count is not a multiple of four. A design that checked for an exact zero would miss this finish and let the count wrap around. The bench also covers a rollover with no gap, where a design that needed an idle cycle would show `busy` low or a stale address. A finish with the other slot empty catches a design that reloads a stale descriptor instead of reporting starvation. The bench also writes to the active slot while the channel runs, which would corrupt the running address if such writes were accepted. Finally, it raises the interrupt while masked and unmasks it afterwards, which catches a design that drops the event instead of holding it pending.

// File: rtl/ppd_pkg.sv
package ppd_pkg;
  typedef enum logic {SZ_BYTE = 1'b0, SZ_WORD = 1'b1} acc_size_e;
  localparam int NUM_SLOTS = 2;
  localparam int STEP_W    = 3;

  function automatic logic [STEP_W-1:0] step_of(acc_size_e s);
    return (s == SZ_WORD) ? 3'd4 : 3'd1;
  endfunction
endpackage

// File: rtl/ppd_desc_bank.sv
module ppd_desc_bank #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [AW-1:0]        wr_base,
  input  logic [CW-1:0]        wr_count,
  input  logic                 busy,
  input  logic                 act_idx,
  input  logic                 clr_en,
  input  logic                 clr_idx,
  output logic [1:0][AW-1:0]   base_q,
  output logic [1:0][CW-1:0]   count_q,
  output logic [1:0]           valid_q
);
  import ppd_pkg::*;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic          hit;
    logic          valid_d;
    logic [AW-1:0] base_d;
    logic [CW-1:0] count_d;

    assign hit = wr_en && (wr_sel == 1'(g)) && !(busy && (act_idx == 1'(g)));

    always_comb begin
      valid_d = valid_q[g];
      base_d  = base_q[g];
      count_d = count_q[g];
      if (clr_en && (clr_idx == 1'(g))) valid_d = 1'b0;
      if (hit) begin
        valid_d = 1'b1;
        base_d  = wr_base;
        count_d = wr_count;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        base_q[g]  <= '0;
        count_q[g] <= '0;
      end else begin
        valid_q[g] <= valid_d;
        if (hit) begin
          base_q[g]  <= base_d;
          count_q[g] <= count_d;
        end
      end
    end
  end
endmodule

// File: rtl/ppd_engine.sv
module ppd_engine #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0][AW-1:0]   base_q,
  input  logic [1:0][CW-1:0]   count_q,
  input  logic [1:0]           valid_q,
  input  logic                 size_word,
  input  logic                 unit_done,
  input  logic                 early_end,
  output logic                 busy,
  output logic                 act_idx,
  output logic [AW-1:0]        cur_addr,
  output logic [CW-1:0]        rem_cnt,
  output logic                 starved,
  output logic                 fin,
  output logic                 fin_match
);
  import ppd_pkg::*;

  logic          busy_d, act_d, starved_d;
  logic [AW-1:0] addr_d;
  logic [CW-1:0] rem_d;
  logic [CW-1:0] step_c;
  logic [AW-1:0] step_a;
  logic          last;
  logic          other;

  assign step_c    = {{(CW-STEP_W){1'b0}}, step_of(acc_size_e'(size_word))};
  assign step_a    = {{(AW-STEP_W){1'b0}}, step_of(acc_size_e'(size_word))};
  assign last      = (rem_cnt <= step_c);
  assign other     = ~act_idx;
  assign fin       = busy && ((unit_done && last) || early_end);
  assign fin_match = unit_done && last;

  always_comb begin
    busy_d    = busy;
    act_d     = act_idx;
    starved_d = starved;
    addr_d    = cur_addr;
    rem_d     = rem_cnt;
    if (fin) begin
      act_d = other;
      if (valid_q[other]) begin
        busy_d    = 1'b1;
        addr_d    = base_q[other];
        rem_d     = count_q[other];
        starved_d = 1'b0;
      end else begin
        busy_d    = 1'b0;
        starved_d = 1'b1;
      end
    end else if (busy && unit_done) begin
      addr_d = cur_addr + step_a;
      rem_d  = rem_cnt - step_c;
    end else if (!busy && valid_q[act_idx]) begin
      busy_d    = 1'b1;
      addr_d    = base_q[act_idx];
      rem_d     = count_q[act_idx];
      starved_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      act_idx  <= 1'b0;
      starved  <= 1'b0;
      cur_addr <= '0;
      rem_cnt  <= '0;
    end else begin
      busy     <= busy_d;
      act_idx  <= act_d;
      starved  <= starved_d;
      cur_addr <= addr_d;
      rem_cnt  <= rem_d;
    end
  end
endmodule

// File: rtl/ppd_status.sv
module ppd_status (
  input  logic clk,
  input  logic rst_n,
  input  logic fin,
  input  logic fin_idx,
  input  logic fin_match,
  input  logic irq_en,
  input  logic irq_ack,
  output logic done,
  output logic done_idx,
  output logic cnt_match,
  output logic irq
);
  logic pend_q, pend_d;
  logic idx_d, match_d;

  always_comb begin
    idx_d   = fin ? fin_idx   : done_idx;
    match_d = fin ? fin_match : cnt_match;
    pend_d  = fin ? 1'b1 : (irq_ack ? 1'b0 : pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      done_idx  <= 1'b0;
      cnt_match <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      done      <= fin;
      done_idx  <= idx_d;
      cnt_match <= match_d;
      pend_q    <= pend_d;
    end
  end

  assign irq = pend_q && irq_en;
endmodule

// File: rtl/pingpong_desc_mgr.sv
module pingpong_desc_mgr #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_base,
  input  logic [CW-1:0] cfg_count,
  input  logic          size_word,
  input  logic          unit_done,
  input  logic          early_end,
  input  logic          irq_en,
  input  logic          irq_ack,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] rem_cnt,
  output logic          busy,
  output logic          active_idx,
  output logic          done,
  output logic          done_idx,
  output logic          cnt_match,
  output logic          starved,
  output logic          irq
);
  logic [1:0][AW-1:0] base_q;
  logic [1:0][CW-1:0] count_q;
  logic [1:0]         valid_q;
  logic               fin, fin_match;

  ppd_desc_bank #(.AW(AW), .CW(CW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr), .wr_sel(cfg_sel), .wr_base(cfg_base), .wr_count(cfg_count),
    .busy(busy), .act_idx(active_idx),
    .clr_en(fin), .clr_idx(active_idx),
    .base_q(base_q), .count_q(count_q), .valid_q(valid_q)
  );

  ppd_engine #(.AW(AW), .CW(CW)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .base_q(base_q), .count_q(count_q), .valid_q(valid_q),
    .size_word(size_word), .unit_done(unit_done), .early_end(early_end),
    .busy(busy), .act_idx(active_idx), .cur_addr(cur_addr), .rem_cnt(rem_cnt),
    .starved(starved), .fin(fin), .fin_match(fin_match)
  );

  ppd_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .fin(fin), .fin_idx(active_idx), .fin_match(fin_match),
    .irq_en(irq_en), .irq_ack(irq_ack),
    .done(done), .done_idx(done_idx), .cnt_match(cnt_match), .irq(irq)
  );
endmodule

// File: rtl/ppd_checker.sv
module ppd_checker #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic          cfg_sel,
  input logic          size_word,
  input logic          unit_done,
  input logic          early_end,
  input logic          irq_en,
  input logic [AW-1:0] cur_addr,
  input logic [CW-1:0] rem_cnt,
  input logic          busy,
  input logic          active_idx,
  input logic          done,
  input logic          cnt_match,
  input logic          starved,
  input logic          irq
);
  logic [AW-1:0] stp_a;
  logic [CW-1:0] stp_c;
  assign stp_a = size_word ? AW'(4) : AW'(1);
  assign stp_c = size_word ? CW'(4) : CW'(1);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && unit_done && !early_end && rem_cnt > stp_c) |=> (cur_addr == $past(cur_addr) + $past(stp_a))); // R3
  AST_FINISH_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && unit_done && rem_cnt <= stp_c) |=> (done && cnt_match)); // R4
  AST_IDX_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (active_idx != $past(active_idx))); // R5
  AST_STARVE_FROM_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(starved) |-> (done && !busy)); // R6
  AST_ACTIVE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && busy && cfg_sel == active_idx && !unit_done && !early_end) |=> ($stable(cur_addr) && $stable(rem_cnt))); // R7
  AST_EARLY_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && early_end && !unit_done) |=> (done && !cnt_match)); // R8
  AST_IRQ_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (done && irq_en) |-> irq); // R9
endmodule

bind pingpong_desc_mgr ppd_checker #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
  .size_word(size_word), .unit_done(unit_done), .early_end(early_end),
  .irq_en(irq_en), .cur_addr(cur_addr), .rem_cnt(rem_cnt), .busy(busy),
  .active_idx(active_idx), .done(done), .cnt_match(cnt_match),
  .starved(starved), .irq(irq)
);

// File: tb/tb_pingpong_desc_mgr.sv
module tb_pingpong_desc_mgr;
  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr, cfg_sel, size_word, unit_done, early_end, irq_en, irq_ack;
  logic [AW-1:0] cfg_base;
  logic [CW-1:0] cfg_count;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] rem_cnt;
  logic          busy, active_idx, done, done_idx, cnt_match, starved, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pingpong_desc_mgr #(.AW(AW), .CW(CW)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write_desc(logic sel, logic [AW-1:0] b, logic [CW-1:0] c);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_base = b; cfg_count = c;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic units(int n);
    for (int i = 0; i < n; i++) begin
      unit_done = 1'b1;
      tick();
    end
    unit_done = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 idx", active_idx, 0);
    chk("R1 done", done, 0);
    chk("R1 irq", irq, 0);
    chk("R1 starved", starved, 0);
    chk("R1 match", cnt_match, 0);
  endtask

  task automatic t_byte_buffer();
    size_word = 1'b0;
    irq_en = 1'b1;
    write_desc(1'b0, 32'h1000, 16'd3);
    tick();
    chk("R2 busy", busy, 1);
    chk("R2 addr", cur_addr, 32'h1000);
    chk("R2 rem", rem_cnt, 3);
    units(1);
    chk("R3 byte addr", cur_addr, 32'h1001);
    chk("R3 byte rem", rem_cnt, 2);
    units(2);
    chk("R4 done", done, 1);
    chk("R4 done_idx", done_idx, 0);
    chk("R4 match", cnt_match, 1);
    chk("R6 starved", starved, 1);
    chk("R6 busy", busy, 0);
    chk("R6 idx", active_idx, 1);
    chk("R9 irq", irq, 1);
    tick();
    chk("R4 pulse one cycle", done, 0);
    ack();
    chk("R9 ack", irq, 0);
  endtask

  task automatic t_word_rollover();
    size_word = 1'b1;
    write_desc(1'b1, 32'h2000, 16'd6);
    tick();
    chk("R6 reload busy", busy, 1);
    chk("R6 starved cleared", starved, 0);
    chk("R2 addr slot1", cur_addr, 32'h2000);
    write_desc(1'b0, 32'h3000, 16'd8);
    write_desc(1'b1, 32'hDEAD, 16'd99);
    chk("R7 addr kept", cur_addr, 32'h2000);
    chk("R7 rem kept", rem_cnt, 6);
    units(1);
    chk("R3 word addr", cur_addr, 32'h2004);
    chk("R3 word rem", rem_cnt, 2);
    units(1);
    chk("R4 partial done", done, 1);
    chk("R4 done_idx", done_idx, 1);
    chk("R4 partial match", cnt_match, 1);
    chk("R5 idx", active_idx, 0);
    chk("R5 busy", busy, 1);
    chk("R5 addr", cur_addr, 32'h3000);
    chk("R5 rem", rem_cnt, 8);
    ack();
  endtask

  task automatic t_early();
    units(1);
    chk("R3 addr", cur_addr, 32'h3004);
    early_end = 1'b1;
    tick();
    early_end = 1'b0;
    chk("R8 done", done, 1);
    chk("R8 match", cnt_match, 0);
    chk("R6 cleared slot starves", starved, 1);
    chk("R6 busy", busy, 0);
    ack();
  endtask

  task automatic t_mask();
    irq_en = 1'b0;
    size_word = 1'b0;
    write_desc(1'b1, 32'h4000, 16'd2);
    tick();
    chk("R2 addr", cur_addr, 32'h4000);
    units(2);
    chk("R4 done", done, 1);
    chk("R9 masked", irq, 0);
    tick();
    irq_en = 1'b1;
    #1;
    chk("R9 pending kept", irq, 1);
    ack();
    chk("R9 cleared", irq, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_base = '0; cfg_count = '0;
    size_word = 1'b0; unit_done = 1'b0; early_end = 1'b0;
    irq_en = 1'b0; irq_ack = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_byte_buffer();
    t_word_rollover();
    t_early();
    t_mask();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule